// File: doc/BRIEF.md
# Misaligned Access Exception Unit

This unit sits beside the load/store path of a processor. For every memory access it checks the two low address bits against the access size. A halfword access faults on an odd address. A word access, which includes the lock and unlock accesses, faults on any address that is not a multiple of four. A faulting access never reaches memory. The unit then takes the exception.

Taking the exception changes processor state at the next clock edge. The three status flags (stack mode, interrupt enable and carry) are copied into a backup set. Interrupt enable and carry are cleared. The exact PC of the faulting instruction is captured. An exception beats an external interrupt that arrives in the same cycle. A return command restores the flags from the backup set and presents a resume PC. That PC is the captured PC with its two low bits forced to zero, so a fault at a halfword offset resumes at the enclosing word.

The execution stage writes the flags through a separate write port. The bit order is the same on every flag vector: bit 2 is stack mode, bit 1 is interrupt enable, bit 0 is carry.

Top module: `mae_unit`

## Requirements
- R1: A halfword access (`acc_word_i`=0, `acc_lock_i`=0) faults when `addr_lo_i` is 01 or 11, and does not fault when it is 00 or 10.
- R2: A word access (`acc_word_i`=1) or a lock access (`acc_lock_i`=1) faults when `addr_lo_i` is 01, 10 or 11, and does not fault when it is 00.
- R3: `mem_en_o` is high exactly when `acc_valid_i` is high and the access does not fault. `exc_o` is high exactly when `acc_valid_i` is high and the access faults. Both are combinational, one clock per access.
- R4: When an exception is taken, `irq_ack_o` stays low even if `ext_irq_i` is high.
- R5: With no exception in that cycle, `irq_ack_o` equals `ext_irq_i` AND interrupt enable (`flags_o[1]`). While interrupt enable is 0, the request is ignored.
- R6: At the clock edge after `exc_o`, `bak_flags_o` holds the value that `flags_o` had in the faulting cycle.
- R7: At the clock edge after `exc_o`, `flags_o[2]` is unchanged and `flags_o[1:0]` are 00.
- R8: At the clock edge after `exc_o`, `bak_pc_o` holds the exact `pc_i` of the faulting cycle. Bit 1 of `bak_pc_o` is 1 for a fault at a halfword offset and 0 for one on a word boundary.
- R9: `resume_vld_o` is high when `ret_i` is high and no exception is taken. `resume_pc_o` is always `bak_pc_o` with bits 1:0 forced to 00.
- R10: At the clock edge after `resume_vld_o`, `flags_o` equals the `bak_flags_o` value of the return cycle.
- R11: When `flags_we_i` is high and neither an exception nor a return is taken, `flags_o` loads `flags_i` at the next edge. An exception or a return overrides the write.
- R12: While `rst_ni` is low, all flags, backups and `bak_pc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A load or store is presented this cycle |
| acc_word_i | input | 1 | 1 = word access, 0 = halfword access |
| acc_lock_i | input | 1 | Lock or unlock access, checked as word |
| addr_lo_i | input | 2 | Two low bits of the access address |
| pc_i | input | PC_W | PC of the current instruction |
| ext_irq_i | input | 1 | External interrupt request |
| ret_i | input | 1 | Return-from-exception command |
| flags_we_i | input | 1 | Flag write from the execution stage |
| flags_i | input | 3 | Flag write data {stack, ien, carry} |
| mem_en_o | output | 1 | Memory access enable |
| exc_o | output | 1 | Address exception taken |
| irq_ack_o | output | 1 | External interrupt accepted |
| flags_o | output | 3 | Current flags {stack, ien, carry} |
| bak_flags_o | output | 3 | Backup flags {stack, ien, carry} |
| bak_pc_o | output | PC_W | PC captured on exception |
| resume_vld_o | output | 1 | Return taken this cycle |
| resume_pc_o | output | PC_W | Word-aligned PC to resume at |

## Verification
The bench builds the unit with PC_W = 24 rather than the default 32. This keeps the captured and resume PCs short enough to read, while the upper bits that must pass through untouched stay well clear of the two low bits that the return path clears. Random PCs exercise every halfword offset. Random mixes of size, lock, interrupt, return and flag writes in the same cycle reach each priority pairing: exception against interrupt, exception against return, and return against flag write. Because the flag write port is random, the interrupt enable toggles often, so masked and unmasked interrupts both occur.

// File: rtl/mae_pkg.sv
package mae_pkg;
  // bit 2 stack mode, bit 1 interrupt enable, bit 0 carry
  typedef struct packed {
    logic stk;
    logic ien;
    logic cry;
  } flags_t;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_EXC  = 2'd1,
    SEL_RET  = 2'd2,
    SEL_WR   = 2'd3
  } flag_sel_e;
endpackage

// File: rtl/mae_align_chk.sv
module mae_align_chk #(
  parameter int LO_W = 2
) (
  input  logic            word_i,
  input  logic            lock_i,
  input  logic [LO_W-1:0] lo_i,
  output logic            fault_o
);
  localparam logic [LO_W-1:0] HW_MASK = LO_W'(1);
  localparam logic [LO_W-1:0] WD_MASK = {LO_W{1'b1}};

  logic [LO_W-1:0] mask;

  // lock/unlock are treated as word accesses
  assign mask    = (word_i || lock_i) ? WD_MASK : HW_MASK;
  assign fault_o = |(lo_i & mask);
endmodule

// File: rtl/mae_flag_bank.sv
module mae_flag_bank
  import mae_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_sel_e sel_i,
  input  flags_t    wr_i,
  output flags_t    cur_o,
  output flags_t    bak_o
);
  flags_t cur_q, bak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      bak_q <= '0;
    end else begin
      unique case (sel_i)
        SEL_EXC: begin
          bak_q <= cur_q;
          cur_q <= '{stk: cur_q.stk, ien: 1'b0, cry: 1'b0};
        end
        SEL_RET:  cur_q <= bak_q;
        SEL_WR:   cur_q <= wr_i;
        default:  ;
      endcase
    end
  end

  assign cur_o = cur_q;
  assign bak_o = bak_q;

  // R6
  bak_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_EXC |=> bak_q == $past(cur_q));
  // R7
  exc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_EXC |=> (!cur_q.ien && !cur_q.cry && cur_q.stk == $past(cur_q.stk)));
  // R10
  ret_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_RET |=> cur_q == $past(bak_q));
endmodule

// File: rtl/mae_pc_save.sv
module mae_pc_save #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] bak_pc_o,
  output logic [PC_W-1:0] resume_pc_o
);
  logic [PC_W-1:0] bak_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bak_pc_q <= '0;
    else if (take_i) bak_pc_q <= pc_i;
  end

  assign bak_pc_o    = bak_pc_q;
  assign resume_pc_o = {bak_pc_q[PC_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  // R8
  pc_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> bak_pc_q == $past(pc_i));
  // R8
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(bak_pc_q));
endmodule

// File: rtl/mae_unit.sv
module mae_unit
  import mae_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_valid_i,
  input  logic            acc_word_i,
  input  logic            acc_lock_i,
  input  logic [1:0]      addr_lo_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            ext_irq_i,
  input  logic            ret_i,
  input  logic            flags_we_i,
  input  logic [2:0]      flags_i,
  output logic            mem_en_o,
  output logic            exc_o,
  output logic            irq_ack_o,
  output logic [2:0]      flags_o,
  output logic [2:0]      bak_flags_o,
  output logic [PC_W-1:0] bak_pc_o,
  output logic            resume_vld_o,
  output logic [PC_W-1:0] resume_pc_o
);
  localparam int LO_W = 2;

  logic      fault;
  logic      exc_take, ret_take;
  flag_sel_e sel;
  flags_t    cur, bak;

  mae_align_chk #(.LO_W(LO_W)) u_align (
    .word_i  (acc_word_i),
    .lock_i  (acc_lock_i),
    .lo_i    (addr_lo_i),
    .fault_o (fault)
  );

  assign exc_take = acc_valid_i && fault;
  assign ret_take = ret_i && !exc_take;

  // priority: exception, return, flag write
  always_comb begin
    if (exc_take)        sel = SEL_EXC;
    else if (ret_take)   sel = SEL_RET;
    else if (flags_we_i) sel = SEL_WR;
    else                 sel = SEL_HOLD;
  end

  mae_flag_bank u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .wr_i   (flags_t'(flags_i)),
    .cur_o  (cur),
    .bak_o  (bak)
  );

  mae_pc_save #(.PC_W(PC_W), .ALIGN_W(LO_W)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (exc_take),
    .pc_i        (pc_i),
    .bak_pc_o    (bak_pc_o),
    .resume_pc_o (resume_pc_o)
  );

  assign mem_en_o     = acc_valid_i && !fault;
  assign exc_o        = exc_take;
  assign irq_ack_o    = ext_irq_i && cur.ien && !exc_take;
  assign resume_vld_o = ret_take;
  assign flags_o      = cur;
  assign bak_flags_o  = bak;

  // R3
  no_mem_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !mem_en_o);
  // R4
  exc_over_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !irq_ack_o);
  // R5
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[1] |-> !irq_ack_o);
  // R11
  flag_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_i && !exc_o && !resume_vld_o) |=> flags_o == $past(flags_i));
endmodule

// File: tb/mae_unit_tb.sv
module mae_unit_tb_top;
  localparam int PC_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v, w, lk, irq, ret, we;
  logic [1:0] lo;
  logic [2:0] fl;
  logic [PC_W-1:0] pc;
  logic mem_en, exc, ack, rv;
  logic [2:0] fo, bo;
  logic [PC_W-1:0] bpc, rpc;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_cur = '0, m_bak = '0;
  logic [PC_W-1:0] m_bpc = '0;

  always #2 clk = ~clk;

  mae_unit #(.PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_word_i(w), .acc_lock_i(lk),
    .addr_lo_i(lo), .pc_i(pc), .ext_irq_i(irq), .ret_i(ret), .flags_we_i(we),
    .flags_i(fl), .mem_en_o(mem_en), .exc_o(exc), .irq_ack_o(ack), .flags_o(fo),
    .bak_flags_o(bo), .bak_pc_o(bpc), .resume_vld_o(rv), .resume_pc_o(rpc)
  );

  function automatic logic mis(logic wd, logic lck, logic [1:0] a);
    return (wd || lck) ? (a != 2'b00) : a[0];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic iv, logic iw, logic il, logic [1:0] ilo, logic [PC_W-1:0] ipc,
                      logic iirq, logic iret, logic iwe, logic [2:0] ifl);
    logic e_exc, e_ret;
    @(negedge clk);
    v = iv; w = iw; lk = il; lo = ilo; pc = ipc; irq = iirq; ret = iret; we = iwe; fl = ifl;
    #1;
    e_exc = iv && mis(iw, il, ilo);
    e_ret = iret && !e_exc;
    if (iw || il) chk("R2 exc", 64'(exc), 64'(e_exc));
    else          chk("R1 exc", 64'(exc), 64'(e_exc));
    chk("R3 mem_en", 64'(mem_en), 64'(iv && !e_exc));
    if (e_exc) chk("R4 irq_ack", 64'(ack), 64'(0));
    else       chk("R5 irq_ack", 64'(ack), 64'(iirq && m_cur[1]));
    chk("R9 resume_vld", 64'(rv), 64'(e_ret));
    chk("R9 resume_pc", 64'(rpc), 64'({m_bpc[PC_W-1:2], 2'b00}));
    if (e_exc) begin
      m_bak = m_cur;
      m_cur = {m_cur[2], 2'b00};
      m_bpc = ipc;
    end else if (e_ret) m_cur = m_bak;
    else if (iwe) m_cur = ifl;
    @(posedge clk); #1;
    if (e_exc) begin
      chk("R6 bak_flags", 64'(bo), 64'(m_bak));
      chk("R7 flags", 64'(fo), 64'(m_cur));
      chk("R8 bak_pc", 64'(bpc), 64'(m_bpc));
      chk("R8 bit1", 64'(bpc[1]), 64'(ipc[1]));
    end else if (e_ret) begin
      chk("R10 flags", 64'(fo), 64'(m_cur));
      chk("R8 bak_pc hold", 64'(bpc), 64'(m_bpc));
    end else begin
      chk("R11 flags", 64'(fo), 64'(m_cur));
      chk("R6 bak hold", 64'(bo), 64'(m_bak));
      chk("R8 bak_pc hold", 64'(bpc), 64'(m_bpc));
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5EED_0041;
    void'($urandom(seed));
    v = 0; w = 0; lk = 0; lo = 0; pc = 0; irq = 0; ret = 0; we = 0; fl = 0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12 flags", 64'(fo), 64'(0));
    chk("R12 bak_flags", 64'(bo), 64'(0));
    chk("R12 bak_pc", 64'(bpc), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    // R11 set all flags
    step(0, 0, 0, 2'b00, 24'h0, 0, 0, 1, 3'b111);
    // R1 halfword at 10 is fine, R5 irq accepted
    step(1, 0, 0, 2'b10, 24'h000010, 1, 0, 0, 3'b000);
    // R1 fault at 01, irq same cycle -> R4, R6, R7, R8 (pc 6)
    step(1, 0, 0, 2'b01, 24'h000006, 1, 0, 0, 3'b000);
    // R5 irq ignored with ien=0
    step(0, 0, 0, 2'b00, 24'h0, 1, 0, 0, 3'b000);
    // R9 resume at 4, R10 restore
    step(0, 0, 0, 2'b00, 24'h0, 0, 1, 1, 3'b010);
    // R2 word at 10 faults, lock at 01 faults, word at 00 fine
    step(1, 1, 0, 2'b10, 24'hABCDE4, 0, 0, 0, 3'b000);
    step(1, 0, 1, 2'b01, 24'h123456, 0, 1, 0, 3'b000);
    step(1, 1, 0, 2'b00, 24'h000100, 0, 0, 0, 3'b000);
    step(1, 0, 0, 2'b11, 24'h000102, 0, 0, 0, 3'b000);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, $urandom % 2, ($urandom % 5) == 0, 2'($urandom),
           PC_W'($urandom), $urandom % 2, ($urandom % 6) == 0, ($urandom % 3) == 0,
           3'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule